// File: doc/BRIEF.md
# Sensor Frame CRC-8 Unit

This unit produces and checks the 8-bit checksum that closes each 32-bit sensor command or response frame. The checksum is computed over the three leading bytes of the frame. Byte 0 is the most significant and is sent first. The computation is the same in both directions: the register is seeded with all ones, bits enter most significant first against the generator x^8+x^4+x^3+x^2+1 (0x1D), and the final remainder is inverted.

Frames reach the unit by one of two paths:
- **Bit-serial:** a frame is opened with a start strobe, and its bits are then presented one per valid cycle as a shift register would deliver them.
- **Parallel:** a whole 32-bit word is presented in a single cycle.

The unit works in one of two modes:
- **Transmit:** the unit appends the checksum to the three payload bytes.
- **Receive:** the unit compares its result with the fourth byte it received and pulses an error flag on a mismatch.

The unit does not drive any SPI pins. It does not interpret any frame field.

Top module: `frame_crc8_unit`

## Requirements
- R1: While and after reset, `done_o`, `crc_err_o` and `busy_o` are 0, and `crc_o` and `frame_o` are all zeros.
- R2: The checksum is computed over frame bits 31:8 (byte 0 in bits 31:24), most significant bit first. The register is seeded with 0xFF, uses polynomial 0x1D, and is inverted at the end. For the payload 0x04,0x00,0x00 this yields the value given by a software model of these rules.
- R3: Parallel transmit: `word_vld_i` with `mode_i`=0 (0 = transmit, 1 = receive) gives `done_o`=1 in the next cycle. In that cycle `crc_o` is the checksum, `frame_o` = {word_i[31:8], checksum}, and `crc_err_o`=0.
- R4: Parallel receive: `word_vld_i` with `mode_i`=1 gives `done_o`=1 in the next cycle, with `frame_o`=word_i and `crc_o` the computed checksum. `crc_err_o` is 1 in that cycle exactly when word_i[7:0] differs from the checksum.
- R5: Serial transmit: after `start_i` with `mode_i`=0, the 24th accepted bit produces `done_o` in the following cycle. The result is the same as for the parallel path, and `frame_o` holds the 24 payload bits followed by the checksum.
- R6: Serial receive: after `start_i` with `mode_i`=1, 32 bits are accepted. The last 8 bits are the received checksum. `done_o` follows the 32nd bit, and `crc_err_o` reports a mismatch as in R4.
- R7: `bit_vld_i` is ignored while `busy_o` is 0 and in the cycle where `start_i` is high.
- R8: `word_vld_i` is ignored while `busy_o` is 1, and also in a cycle where `start_i` is high; no `done_o` follows.
- R9: `start_i` during an open serial frame reseeds the checksum and restarts the bit count.
- R10: `crc_err_o` is 1 only together with `done_o`. It lasts one cycle per completed frame.
- R11: `busy_o` rises in the cycle after `start_i` and falls in the cycle where the serial `done_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens (or reopens) a serial frame |
| mode_i | input | 1 | 0 transmit, 1 receive; sampled with start_i or word_vld_i |
| bit_vld_i | input | 1 | Serial bit valid |
| bit_i | input | 1 | Serial bit, most significant first |
| word_vld_i | input | 1 | Parallel word valid |
| word_i | input | 32 | Parallel frame word |
| busy_o | output | 1 | Serial frame open |
| done_o | output | 1 | Result valid for one cycle |
| crc_o | output | 8 | Computed inverted checksum |
| frame_o | output | 32 | Completed frame (transmit: appended, receive: as received) |
| crc_err_o | output | 1 | Receive checksum mismatch pulse |

## Verification
Two situations can fall in the same cycle: a parallel word request arriving while a serial frame is open, and a start strobe arriving together with a word request. The bench provokes both. It presents a word in the middle of a serial frame, and it raises `start_i` and `word_vld_i` in the same cycle. It then expects no `done_o` in the following cycle. The interrupted serial frame must still finish with the checksum computed by the bench's own model.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;
  typedef enum logic {MODE_TX = 1'b0, MODE_RX = 1'b1} mode_e;
  localparam int unsigned DEF_DATA_BITS = 24;
  localparam int unsigned DEF_CRC_W     = 8;
endpackage

// File: rtl/fcrc_bit_engine.sv
module fcrc_bit_engine #(
  parameter int unsigned      CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h1D,
  parameter logic [CRC_W-1:0] SEED  = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] state_o,
  output logic [CRC_W-1:0] next_o
);
  logic [CRC_W-1:0] state_q;

  always_comb begin
    next_o = {state_q[CRC_W-2:0], 1'b0} ^ ((state_q[CRC_W-1] ^ bit_i) ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) state_q <= SEED;
    else if (shift_i)   state_q <= next_o;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fcrc_word_engine.sv
module fcrc_word_engine #(
  parameter int unsigned      DATA_BITS = 24,
  parameter int unsigned      CRC_W     = 8,
  parameter logic [CRC_W-1:0] POLY      = 8'h1D,
  parameter logic [CRC_W-1:0] SEED      = 8'hFF
) (
  input  logic [DATA_BITS-1:0] data_i,
  output logic [CRC_W-1:0]     crc_o
);
  logic [CRC_W-1:0] stage [0:DATA_BITS];

  assign stage[0] = SEED;

  for (genvar g = 0; g < DATA_BITS; g++) begin : g_step
    assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0}
                      ^ ((stage[g][CRC_W-1] ^ data_i[DATA_BITS-1-g]) ? POLY : '0);
  end

  assign crc_o = ~stage[DATA_BITS];
endmodule

// File: rtl/frame_crc8_unit.sv
module frame_crc8_unit #(
  parameter int unsigned      DATA_BITS = fcrc_pkg::DEF_DATA_BITS,
  parameter int unsigned      CRC_W     = fcrc_pkg::DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY      = 8'h1D,
  parameter logic [CRC_W-1:0] SEED      = 8'hFF,
  localparam int unsigned     FRAME_W   = DATA_BITS + CRC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  input  logic               word_vld_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CRC_W-1:0]   crc_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               crc_err_o
);
  import fcrc_pkg::*;

  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] PAY_END = CNT_W'(DATA_BITS);

  logic             busy_q;
  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sh_q, sh_next;
  logic [CRC_W-1:0] eng_state, eng_next, word_crc;
  logic             acc_bit, in_payload, last_tx, last_rx, word_go;

  assign acc_bit    = busy_q && bit_vld_i && !start_i;
  assign in_payload = cnt_q < PAY_END;
  assign last_tx    = acc_bit && (mode_q == MODE_TX) && (cnt_q == LAST_TX);
  assign last_rx    = acc_bit && (mode_q == MODE_RX) && (cnt_q == LAST_RX);
  assign word_go    = word_vld_i && !busy_q && !start_i;
  assign sh_next    = {sh_q[FRAME_W-2:0], bit_i};

  fcrc_bit_engine #(.CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_i),
    .shift_i (acc_bit && in_payload),
    .bit_i   (bit_i),
    .state_o (eng_state),
    .next_o  (eng_next)
  );

  fcrc_word_engine #(.DATA_BITS(DATA_BITS), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_word (
    .data_i (word_i[FRAME_W-1:CRC_W]),
    .crc_o  (word_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      mode_q    <= MODE_TX;
      cnt_q     <= '0;
      sh_q      <= '0;
      done_o    <= 1'b0;
      crc_err_o <= 1'b0;
      crc_o     <= '0;
      frame_o   <= '0;
    end else begin
      done_o    <= 1'b0;
      crc_err_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        mode_q <= mode_e'(mode_i);
        cnt_q  <= '0;
      end else if (acc_bit) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= sh_next;
        if (last_tx) begin
          busy_q  <= 1'b0;
          done_o  <= 1'b1;
          crc_o   <= ~eng_next;
          frame_o <= {sh_next[DATA_BITS-1:0], ~eng_next};
        end else if (last_rx) begin
          busy_q    <= 1'b0;
          done_o    <= 1'b1;
          crc_o     <= ~eng_state;
          frame_o   <= sh_next;
          crc_err_o <= sh_next[CRC_W-1:0] != ~eng_state;
        end
      end
      if (word_go) begin
        done_o <= 1'b1;
        crc_o  <= word_crc;
        if (mode_e'(mode_i) == MODE_RX) begin
          frame_o   <= word_i;
          crc_err_o <= word_i[CRC_W-1:0] != word_crc;
        end else begin
          frame_o <= {word_i[FRAME_W-1:CRC_W], word_crc};
        end
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/frame_crc8_checker.sv
module frame_crc8_checker #(
  parameter int unsigned CRC_W   = 8,
  parameter int unsigned FRAME_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               bit_vld_i,
  input logic               word_vld_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [CRC_W-1:0]   crc_o,
  input logic [FRAME_W-1:0] frame_o,
  input logic               crc_err_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && !busy_o && !crc_err_o));

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    crc_err_o |-> done_o);

  a_r4_low_byte: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (frame_o[CRC_W-1:0] == crc_o) || crc_err_o);

  a_r7_idle_no_done: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !word_vld_i) |=> !done_o);

  a_r8_word_blocked: assert property (@(posedge clk) disable iff (rst)
    (busy_o && word_vld_i && !bit_vld_i) |=> !done_o);

  a_r11_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);

  a_r11_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
endmodule

bind frame_crc8_unit frame_crc8_checker #(.CRC_W(CRC_W), .FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .bit_vld_i  (bit_vld_i),
  .word_vld_i (word_vld_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .crc_o      (crc_o),
  .frame_o    (frame_o),
  .crc_err_o  (crc_err_o)
);

// File: tb/frame_crc8_unit_bench.sv
module frame_crc8_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, mode_i = 0, bit_vld_i = 0, bit_i = 0, word_vld_i = 0;
  logic [31:0] word_i = '0;
  logic busy_o, done_o, crc_err_o;
  logic [7:0] crc_o;
  logic [31:0] frame_o;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_crc8_unit u_frame_crc8_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .word_vld_i(word_vld_i),
    .word_i(word_i), .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o),
    .frame_o(frame_o), .crc_err_o(crc_err_o)
  );

  function automatic logic [7:0] model(input logic [23:0] d);
    logic [7:0] c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return ~c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 done", 32'(done_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 err", 32'(crc_err_o), 0);
    chk("R1 crc", 32'(crc_o), 0);
    chk("R1 frame", frame_o, 0);
  endtask

  task automatic t_word(input logic m, input logic [31:0] w, input string req);
    logic [7:0] c = model(w[31:8]);
    @(negedge clk); word_vld_i = 1; mode_i = m; word_i = w;
    @(negedge clk); word_vld_i = 0;
    chk({req, " done"}, 32'(done_o), 1);
    chk({req, " R2 crc"}, 32'(crc_o), 32'(c));
    chk({req, " frame"}, frame_o, m ? w : {w[31:8], c});
    chk({req, " err"}, 32'(crc_err_o), 32'(m && (w[7:0] != c)));
    @(negedge clk);
    chk("R10 done single", 32'(done_o), 0);
    chk("R10 err single", 32'(crc_err_o), 0);
  endtask

  task automatic send_bits(input logic [31:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      bit_vld_i = 1; bit_i = f[31-i];
      @(negedge clk);
    end
    bit_vld_i = 0;
  endtask

  task automatic t_serial(input logic m, input logic [31:0] f, input string req);
    logic [7:0] c = model(f[31:8]);
    @(negedge clk); start_i = 1; mode_i = m;
    @(negedge clk); start_i = 0;
    chk("R11 busy after start", 32'(busy_o), 1);
    send_bits(f, m ? 32 : 24);
    chk({req, " done"}, 32'(done_o), 1);
    chk({req, " R2 crc"}, 32'(crc_o), 32'(c));
    chk({req, " frame"}, frame_o, m ? f : {f[31:8], c});
    chk({req, " err"}, 32'(crc_err_o), 32'(m && (f[7:0] != c)));
    chk("R11 busy cleared", 32'(busy_o), 0);
  endtask

  task automatic t_idle_bits;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); bit_vld_i = 1; bit_i = i[0];
      chk("R7 idle no done", 32'(done_o), 0);
    end
    @(negedge clk); bit_vld_i = 0;
    chk("R7 idle no done", 32'(done_o), 0);
    t_serial(0, 32'h5A_C3_0F_00, "R7 after idle bits");
  endtask

  task automatic t_word_busy;
    logic [31:0] f = 32'h12_34_56_00;
    @(negedge clk); start_i = 1; mode_i = 0;
    @(negedge clk); start_i = 0;
    send_bits(f, 10);
    word_vld_i = 1; mode_i = 1; word_i = 32'hDEADBEEF;
    @(negedge clk); word_vld_i = 0;
    chk("R8 word while busy", 32'(done_o), 0);
    for (int i = 10; i < 24; i++) begin
      bit_vld_i = 1; bit_i = f[31-i];
      @(negedge clk);
    end
    bit_vld_i = 0;
    chk("R8 serial result intact", 32'(crc_o), 32'(model(f[31:8])));
    chk("R8 serial done", 32'(done_o), 1);
  endtask

  task automatic t_start_word;
    @(negedge clk); start_i = 1; word_vld_i = 1; mode_i = 0; word_i = 32'h04000000;
    @(negedge clk); start_i = 0; word_vld_i = 0;
    chk("R8 start beats word", 32'(done_o), 0);
    chk("R8 busy", 32'(busy_o), 1);
    send_bits(32'h0, 24);
    chk("R8 frame after clash", 32'(crc_o), 32'(model(24'h0)));
  endtask

  task automatic t_restart;
    logic [31:0] f = 32'h04_00_00_00;
    @(negedge clk); start_i = 1; mode_i = 1;
    @(negedge clk); start_i = 0;
    send_bits(32'hFFFFFFFF, 11);
    start_i = 1; mode_i = 0; bit_vld_i = 1; bit_i = 1;
    @(negedge clk); start_i = 0; bit_vld_i = 0;
    chk("R9 no done on restart", 32'(done_o), 0);
    send_bits(f, 24);
    chk("R9 restarted done", 32'(done_o), 1);
    chk("R9 restarted crc", 32'(crc_o), 32'(model(24'h040000)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_word(0, 32'h04_00_00_00, "R3 R2 read reg1");
    t_word(0, 32'h80_34_12_AA, "R3 pattern");
    t_word(1, {24'hB4_00_1F, model(24'hB4001F)}, "R4 good");
    t_word(1, {24'hB4_00_1F, ~model(24'hB4001F)}, "R4 bad");
    t_serial(0, 32'h04_00_00_00, "R5 read reg1");
    t_serial(0, 32'hFF_FF_FF_00, "R5 ones");
    t_serial(1, {24'h19_C0_01, model(24'h19C001)}, "R6 good");
    t_serial(1, {24'h19_C0_01, model(24'h19C001) ^ 8'h01}, "R6 bad");
    t_idle_bits();
    t_word_busy();
    t_start_word();
    t_restart();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule